// File: doc/BRIEF.md
# Write Unlock Sequencer

This block sits in front of the byte-load path of a paged non-volatile memory and decides whether each incoming write strobe may reach the page loader. Protection is always in force. A host opens the write path by issuing three command writes in a fixed order. Those command bytes are consumed and are never passed on. Every write after the third command is forwarded to the loader until the loader signals that its programming cycle has finished. At that point the sequencer locks again on its own.

A write that arrives while the path is locked stores nothing. It raises a one-cycle pulse that starts a dummy busy period, so that status polling behaves as if a program cycle were running. A write that breaks the command order has the same effect and sends the sequencer back to its first step. For a configurable number of clock cycles after reset release, every write strobe is ignored.

All outputs are registered. They respond in the clock cycle that follows the strobe.

Top module: `write_unlock_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `locked` is 1 and `fwd_stb` and `busy_start` are 0.
- R2: The unlock order is data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA, then data 0xA0 at address 0x5555. Only address bits 14:0 are compared, and bits above 14 are ignored.
- R3: A command strobe that matches the expected step produces neither `fwd_stb` nor `busy_start`. `locked` stays 1 until the third step is accepted and reads 0 in the cycle after it.
- R4: While locked, a strobe that does not match the expected step raises `busy_start` for one cycle in the next cycle and forwards nothing. The sequence restarts at step one, and the offending strobe does not count as step one.
- R5: While unlocked, every strobe is forwarded in the next cycle: `fwd_stb` is 1, and `fwd_addr` and `fwd_data` equal the strobe's address and data. `fwd_first` is 1 only on the first forwarded write after an unlock.
- R6: A `prog_done` pulse returns the sequencer to locked step one from any state. `locked` reads 1 in the cycle after the pulse.
- R7: Strobes sampled on the first POR_CYCLES clock edges after reset release are ignored. They cause no output and no progress through the sequence.
- R8: A strobe sampled on the same edge as `prog_done` is dropped. It produces neither `fwd_stb` nor `busy_start`.
- R9: `fwd_stb` and `busy_start` are never high together, and each goes high only in the cycle after a sampled strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Byte write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_done | input | 1 | Pulse from the loader when a programming cycle ends |
| fwd_stb | output | 1 | Forwarded write strobe to the page loader |
| fwd_first | output | 1 | Marks the first forwarded write, which starts a page load |
| fwd_addr | output | ADDR_W | Address of the forwarded write |
| fwd_data | output | DATA_W | Data of the forwarded write |
| busy_start | output | 1 | Pulse that starts a dummy busy period |
| locked | output | 1 | 1 while writes are blocked |

## Verification
The properties assume that `wr_stb` is a single-cycle pulse per write. They also assume that `prog_done` arrives only as a pulse and never together with reset. The stimulus drives each write for exactly one cycle and leaves an idle cycle between writes. It raises `prog_done` for one cycle, either on its own or, in one deliberate case, on the same edge as a strobe. Addresses deliberately carry bits above 14 in some commands, to show that those bits play no part in the comparison.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

  typedef enum logic [1:0] {
    ST_STEP1 = 2'd0,
    ST_STEP2 = 2'd1,
    ST_STEP3 = 2'd2,
    ST_OPEN  = 2'd3
  } seq_state_t;

  localparam int N_STEPS = 3;
  localparam int CMD_AW  = 15;

  function automatic logic [CMD_AW-1:0] step_addr(input int idx);
    return (idx == 1) ? 15'h2AAA : 15'h5555;
  endfunction

  function automatic logic [7:0] step_data(input int idx);
    case (idx)
      0:       return 8'hAA;
      1:       return 8'h55;
      default: return 8'hA0;
    endcase
  endfunction

endpackage

// File: rtl/wpu_por_timer.sv
module wpu_por_timer #(
  parameter int POR_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int CW = (POR_CYCLES < 1) ? 1 : $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/wpu_cmd_match.sv
module wpu_cmd_match
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        step,
  output logic              hit
);
  logic [3:0] step_hit;

  for (genvar i = 0; i < 4; i++) begin : g_step
    if (i < N_STEPS) begin : g_cmd
      assign step_hit[i] = (addr[CMD_AW-1:0] == step_addr(i)) &&
                           (data == DATA_W'(step_data(i)));
    end else begin : g_none
      assign step_hit[i] = 1'b0;
    end
  end

  assign hit = step_hit[step];
endmodule

// File: rtl/wpu_seq_fsm.sv
module wpu_seq_fsm
  import wpu_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              stb,
  input  logic              hit,
  input  logic              done,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [1:0]        step,
  output logic              fwd_stb,
  output logic              fwd_first,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              busy_start,
  output logic              locked
);
  seq_state_t st, st_n;
  logic       first_q, first_n;
  logic       f_stb, f_first, b_start;

  always_comb begin
    st_n    = st;
    first_n = first_q;
    f_stb   = 1'b0;
    f_first = 1'b0;
    b_start = 1'b0;
    if (done) begin
      st_n    = ST_STEP1;
      first_n = 1'b0;
    end else if (stb && en) begin
      if (st == ST_OPEN) begin
        f_stb   = 1'b1;
        f_first = first_q;
        first_n = 1'b0;
      end else if (hit) begin
        case (st)
          ST_STEP1: st_n = ST_STEP2;
          ST_STEP2: st_n = ST_STEP3;
          default: begin
            st_n    = ST_OPEN;
            first_n = 1'b1;
          end
        endcase
      end else begin
        b_start = 1'b1;
        st_n    = ST_STEP1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_STEP1;
      first_q    <= 1'b0;
      fwd_stb    <= 1'b0;
      fwd_first  <= 1'b0;
      busy_start <= 1'b0;
      locked     <= 1'b1;
    end else begin
      st         <= st_n;
      first_q    <= first_n;
      fwd_stb    <= f_stb;
      fwd_first  <= f_first;
      busy_start <= b_start;
      locked     <= (st_n != ST_OPEN);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_addr <= '0;
      fwd_data <= '0;
    end else if (f_stb) begin
      fwd_addr <= addr;
      fwd_data <= data;
    end
  end

  assign step = st;
endmodule

// File: rtl/write_unlock_seq.sv
module write_unlock_seq #(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int POR_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              fwd_stb,
  output logic              fwd_first,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              busy_start,
  output logic              locked
);
  logic       por_ready;
  logic       cmd_hit;
  logic [1:0] cur_step;

  wpu_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk   (clk),
    .rst   (rst),
    .ready (por_ready)
  );

  wpu_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .addr (wr_addr),
    .data (wr_data),
    .step (cur_step),
    .hit  (cmd_hit)
  );

  wpu_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (por_ready),
    .stb        (wr_stb),
    .hit        (cmd_hit),
    .done       (prog_done),
    .addr       (wr_addr),
    .data       (wr_data),
    .step       (cur_step),
    .fwd_stb    (fwd_stb),
    .fwd_first  (fwd_first),
    .fwd_addr   (fwd_addr),
    .fwd_data   (fwd_data),
    .busy_start (busy_start),
    .locked     (locked)
  );
endmodule

// File: rtl/wpu_checker.sv
module wpu_checker #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_done,
  input logic              fwd_stb,
  input logic              busy_start,
  input logic              locked
);
  // R9
  excl_out_chk: assert property (@(posedge clk) disable iff (rst)
    !(fwd_stb && busy_start));

  // R9
  fwd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_stb |-> $past(wr_stb));

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
    busy_start |-> $past(wr_stb));

  // R5
  fwd_open_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_stb |-> !locked);

  // R4
  busy_locked_chk: assert property (@(posedge clk) disable iff (rst)
    busy_start |-> locked);

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (rst)
    $past(prog_done) |-> locked);

  // R8
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $past(prog_done) |-> (!fwd_stb && !busy_start));

  // R2
  unlock_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(wr_stb) && $past(wr_addr[14:0]) == 15'h5555
                       && $past(wr_data) == DATA_W'(8'hA0)));
endmodule

bind write_unlock_seq wpu_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .prog_done  (prog_done),
  .fwd_stb    (fwd_stb),
  .busy_start (busy_start),
  .locked     (locked)
);

// File: tb/write_unlock_seq_test.sv
module write_unlock_seq_test;
  localparam int AW  = 17;
  localparam int DW  = 8;
  localparam int POR = 40;

  localparam int K_NONE = 0;
  localparam int K_FWD  = 1;
  localparam int K_BUSY = 2;

  typedef struct {
    int          kind;
    logic        first;
    logic        lock;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string       req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          prog_done = 1'b0;
  logic          fwd_stb, fwd_first, busy_start, locked;
  logic [AW-1:0] fwd_addr;
  logic [DW-1:0] fwd_data;

  int   n_tests = 0;
  int   n_fail  = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  write_unlock_seq #(.ADDR_W(AW), .DATA_W(DW), .POR_CYCLES(POR)) uut (
    .clk        (clk),
    .rst        (rst),
    .wr_stb     (wr_stb),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_done  (prog_done),
    .fwd_stb    (fwd_stb),
    .fwd_first  (fwd_first),
    .fwd_addr   (fwd_addr),
    .fwd_data   (fwd_data),
    .busy_start (busy_start),
    .locked     (locked)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int kind,
                    input logic first, input logic lock, input string req,
                    input logic with_done = 1'b0);
    exp_t e;
    @(negedge clk);
    wr_addr   = a;
    wr_data   = d;
    wr_stb    = 1'b1;
    prog_done = with_done;
    e.kind = kind; e.first = first; e.lock = lock; e.addr = a; e.data = d; e.req = req;
    sb.push_back(e);
    @(negedge clk);
    wr_stb    = 1'b0;
    prog_done = 1'b0;
  endtask

  task automatic pulse_done(input string req);
    @(negedge clk);
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
    n_tests++;
    if (locked !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: locked after done act=%b exp=1", req, locked);
    end
  endtask

  // Monitor: compare one scoreboard item per sampled strobe
  always begin
    @(posedge clk);
    #2;
    if (!rst) begin
      if (wr_stb) begin
        exp_t e;
        logic ok;
        e = sb.pop_front();
        ok = (locked === e.lock);
        case (e.kind)
          K_FWD:  ok = ok && fwd_stb === 1'b1 && busy_start === 1'b0 &&
                       fwd_first === e.first && fwd_addr === e.addr && fwd_data === e.data;
          K_BUSY: ok = ok && busy_start === 1'b1 && fwd_stb === 1'b0;
          default: ok = ok && busy_start === 1'b0 && fwd_stb === 1'b0;
        endcase
        n_tests++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: act fwd=%b first=%b busy=%b lock=%b addr=%h data=%h exp kind=%0d first=%b lock=%b addr=%h data=%h",
                   e.req, fwd_stb, fwd_first, busy_start, locked, fwd_addr, fwd_data,
                   e.kind, e.first, e.lock, e.addr, e.data);
        end
      end else if (fwd_stb !== 1'b0 || busy_start !== 1'b0) begin
        n_tests++;
        n_fail++;
        $display("FAIL R9: output without strobe act fwd=%b busy=%b exp 0 0", fwd_stb, busy_start);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state while held
    n_tests++;
    if (locked !== 1'b1 || fwd_stb !== 1'b0 || busy_start !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: act lock=%b fwd=%b busy=%b exp 1 0 0", locked, fwd_stb, busy_start);
    end
    rst = 1'b0;

    // R7 power-on lockout: full unlock and a write are all ignored
    wr(17'h05555, 8'hAA, K_NONE, 1'b0, 1'b1, "R7");
    wr(17'h02AAA, 8'h55, K_NONE, 1'b0, 1'b1, "R7");
    wr(17'h05555, 8'hA0, K_NONE, 1'b0, 1'b1, "R7");
    wr(17'h00123, 8'h11, K_NONE, 1'b0, 1'b1, "R7");
    repeat (POR + 5) @(negedge clk);

    // R4 plain write while locked
    wr(17'h00123, 8'h11, K_BUSY, 1'b0, 1'b1, "R4");

    // R2 R3 unlock
    wr(17'h05555, 8'hAA, K_NONE, 1'b0, 1'b1, "R3");
    wr(17'h02AAA, 8'h55, K_NONE, 1'b0, 1'b1, "R3");
    wr(17'h05555, 8'hA0, K_NONE, 1'b0, 1'b0, "R2");

    // R5 forwarding
    wr(17'h00200, 8'h5A, K_FWD, 1'b1, 1'b0, "R5");
    wr(17'h00213, 8'hC3, K_FWD, 1'b0, 1'b0, "R5");

    // R6 relock
    pulse_done("R6");
    wr(17'h00200, 8'h77, K_BUSY, 1'b0, 1'b1, "R6");

    // R4 wrong address at step two, then restart from step one
    wr(17'h05555, 8'hAA, K_NONE, 1'b0, 1'b1, "R4");
    wr(17'h02AAB, 8'h55, K_BUSY, 1'b0, 1'b1, "R4");
    wr(17'h05555, 8'hA0, K_BUSY, 1'b0, 1'b1, "R4");

    // R4 wrong data at step two
    wr(17'h05555, 8'hAA, K_NONE, 1'b0, 1'b1, "R4");
    wr(17'h02AAA, 8'h54, K_BUSY, 1'b0, 1'b1, "R4");

    // R6 done in the middle of a sequence
    wr(17'h05555, 8'hAA, K_NONE, 1'b0, 1'b1, "R6");
    pulse_done("R6");
    wr(17'h02AAA, 8'h55, K_BUSY, 1'b0, 1'b1, "R6");

    // R2 upper address bits ignored
    wr(17'h15555, 8'hAA, K_NONE, 1'b0, 1'b1, "R2");
    wr(17'h0AAAA, 8'h55, K_NONE, 1'b0, 1'b1, "R2");
    wr(17'h1D555, 8'hA0, K_NONE, 1'b0, 1'b0, "R2");
    wr(17'h1FFFF, 8'h0F, K_FWD, 1'b1, 1'b0, "R5");

    // R8 strobe together with done is dropped
    wr(17'h01234, 8'h99, K_NONE, 1'b0, 1'b1, "R8", 1'b1);
    wr(17'h00001, 8'h01, K_BUSY, 1'b0, 1'b1, "R8");

    repeat (4) @(negedge clk);
    n_tests++;
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL R9: unchecked items act=%0d exp=0", sb.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule